// File: doc/BRIEF.md
# DRAM Page Hit Classifier

This passive monitor sits beside a memory controller and watches an already decoded DDR4 command stream. It samples one command per rising clock edge. For every bank it records whether a row is open, which row it is, and whether that row has had a column access since it was activated. From this state it sorts each event into one of three outcomes:

- a **page hit**, when a read or write lands on the row that is open;
- a **page miss**, when a read or write finds its bank closed or a different row open, or when an activate arrives at a bank that is already open;
- an **unused page**, when a row is closed without ever having been read or written.

All results go into saturating counters. There is one counter per bank for each of six events: read hit, read miss, write hit, write miss, activate miss and unused page. The counters can be zeroed together at any time.

Each counter array is a flat bus of `NB` slices, each `CNT_W` bits wide. Rank, bank group and bank counts must be powers of two, and each must be at least two. Counts update one cycle after the command that causes them.

Top module: `dram_page_monitor`

## Requirements
- R1: While `rst_ni` is low and after its release, every counter reads zero and every bank is closed, so a first read or write to any bank counts as a miss.
- R2: A read (cmd code 2) or write (cmd code 3) to an open bank whose open row equals `row_i` adds one to that bank's read-hit or write-hit counter in the cycle after the command, and marks the row as accessed.
- R3: A read or write to a closed bank, or to an open bank holding a different row, adds one to that bank's read-miss or write-miss counter. The bank's state is left unchanged, and the row is not marked accessed.
- R4: An activate (cmd code 1) to an already open bank adds one to its activate-miss counter. In every case an activate opens `row_i` with the accessed mark cleared.
- R5: A single-bank precharge (cmd code 4) closes an open bank and adds one to its unused counter only if the row was never accessed; a precharge to a closed bank changes nothing.
- R6: A precharge-all (cmd code 5) applies the R5 rule to every open bank of the rank in `rank_i` and leaves the other ranks untouched; `bg_i` and `ba_i` are ignored.
- R7: A read or write with `ap_i` high is classified first. The bank is then closed, and the close follows the R5 unused rule, so a missed access to an unaccessed open row also counts one unused page. `ap_i` on a closed bank changes no state.
- R8: Every counter saturates at its all-ones value and never wraps or decreases except through clear.
- R9: `clr_i` high zeroes every counter on the next edge and wins over any event in the same cycle; bank state still updates from that cycle's command.
- R10: A cycle with `cmd_valid_i` low, or with cmd code 0, 6 or 7, changes neither counters nor bank state.
- R11: The slice of bank (rank r, group g, bank b) sits at index ((r*NUM_BG)+g)*BANKS_PER_BG+b. That slice occupies bits [idx*CNT_W +: CNT_W] of every counter bus.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Memory clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| clr_i | input | 1 | Synchronous clear of all counters |
| cmd_valid_i | input | 1 | Command qualifier |
| cmd_i | input | 3 | Command code (1 ACT, 2 RD, 3 WR, 4 PRE, 5 PREA) |
| ap_i | input | 1 | Auto-precharge on RD/WR |
| rank_i | input | RANK_W | Target rank |
| bg_i | input | BG_W | Target bank group |
| ba_i | input | BA_W | Target bank within group |
| row_i | input | ROW_W | Row address of the command |
| rd_hit_cnt_o | output | NB*CNT_W | Read hits per bank |
| rd_miss_cnt_o | output | NB*CNT_W | Read misses per bank |
| wr_hit_cnt_o | output | NB*CNT_W | Write hits per bank |
| wr_miss_cnt_o | output | NB*CNT_W | Write misses per bank |
| act_miss_cnt_o | output | NB*CNT_W | Activates to open banks per bank |
| unused_cnt_o | output | NB*CNT_W | Rows closed without access per bank |

## Verification
The bench walks every bank through every state and transition, and compares all six counter buses in full after each command. This catches a slice decoded to the wrong bank as well as a miss on the wrong event.

Precharge-all is issued with banks open in both ranks. A design that ignores the rank would close the wrong rank's rows and count unused pages there.

Auto-precharge is exercised on both a hit and a wrong-row miss. A design that closes the bank before classifying would report a miss instead of a hit. A design that skips the unused check on that close would lose an unused page.

A narrow counter is driven past its maximum, which exposes wrap-around. Clear is raised in the same cycle as a hit, which exposes both a lost clear and a lost state update.

// File: rtl/dram_page_pkg.sv
package dram_page_pkg;
  typedef enum logic [2:0] {
    CMD_NOP  = 3'd0,
    CMD_ACT  = 3'd1,
    CMD_RD   = 3'd2,
    CMD_WR   = 3'd3,
    CMD_PRE  = 3'd4,
    CMD_PREA = 3'd5
  } cmd_e;

  localparam int unsigned EV_N        = 6;
  localparam int unsigned EV_RD_HIT   = 0;
  localparam int unsigned EV_RD_MISS  = 1;
  localparam int unsigned EV_WR_HIT   = 2;
  localparam int unsigned EV_WR_MISS  = 3;
  localparam int unsigned EV_ACT_MISS = 4;
  localparam int unsigned EV_UNUSED   = 5;
endpackage

// File: rtl/dram_sat_counter.sv
module dram_sat_counter #(
  parameter int unsigned W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         inc_i,
  output logic [W-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                   q_o <= '0;
    else if (clr_i)                q_o <= '0;
    else if (inc_i && q_o != '1)   q_o <= q_o + 1'b1;
  end
endmodule

// File: rtl/dram_bank_tracker.sv
module dram_bank_tracker
  import dram_page_pkg::*;
#(
  parameter int unsigned ROW_W = 17
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             valid_i,
  input  logic [2:0]       cmd_i,
  input  logic             sel_i,
  input  logic             rank_sel_i,
  input  logic             ap_i,
  input  logic [ROW_W-1:0] row_i,
  output logic [EV_N-1:0]  ev_o
);
  logic             open_q, acc_q;
  logic [ROW_W-1:0] row_q;

  logic is_act, is_rd, is_wr, is_acc, is_hit, do_close;

  always_comb begin
    is_act   = valid_i && sel_i && (cmd_i == CMD_ACT);
    is_rd    = valid_i && sel_i && (cmd_i == CMD_RD);
    is_wr    = valid_i && sel_i && (cmd_i == CMD_WR);
    is_acc   = is_rd || is_wr;
    is_hit   = is_acc && open_q && (row_q == row_i);
    // classification first, then the close from AP/PRE/PREA
    do_close = open_q && ((valid_i && sel_i && cmd_i == CMD_PRE) ||
                          (valid_i && rank_sel_i && cmd_i == CMD_PREA) ||
                          (is_acc && ap_i));
    ev_o                 = '0;
    ev_o[EV_RD_HIT]      = is_rd && is_hit;
    ev_o[EV_RD_MISS]     = is_rd && !is_hit;
    ev_o[EV_WR_HIT]      = is_wr && is_hit;
    ev_o[EV_WR_MISS]     = is_wr && !is_hit;
    ev_o[EV_ACT_MISS]    = is_act && open_q;
    ev_o[EV_UNUSED]      = do_close && !(acc_q || is_hit);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      open_q <= 1'b0;
      acc_q  <= 1'b0;
      row_q  <= '0;
    end else if (is_act) begin
      open_q <= 1'b1;
      acc_q  <= 1'b0;
      row_q  <= row_i;
    end else if (do_close) begin
      open_q <= 1'b0;
      acc_q  <= 1'b0;
    end else if (is_hit) begin
      acc_q  <= 1'b1;
    end
  end
endmodule

// File: rtl/dram_page_monitor.sv
module dram_page_monitor
  import dram_page_pkg::*;
#(
  parameter int unsigned NUM_RANKS    = 2,
  parameter int unsigned NUM_BG       = 4,
  parameter int unsigned BANKS_PER_BG = 4,
  parameter int unsigned ROW_W        = 17,
  parameter int unsigned CNT_W        = 32,
  localparam int unsigned RANK_W = $clog2(NUM_RANKS),
  localparam int unsigned BG_W   = $clog2(NUM_BG),
  localparam int unsigned BA_W   = $clog2(BANKS_PER_BG),
  localparam int unsigned NB     = NUM_RANKS * NUM_BG * BANKS_PER_BG
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                clr_i,
  input  logic                cmd_valid_i,
  input  logic [2:0]          cmd_i,
  input  logic                ap_i,
  input  logic [RANK_W-1:0]   rank_i,
  input  logic [BG_W-1:0]     bg_i,
  input  logic [BA_W-1:0]     ba_i,
  input  logic [ROW_W-1:0]    row_i,
  output logic [NB*CNT_W-1:0] rd_hit_cnt_o,
  output logic [NB*CNT_W-1:0] rd_miss_cnt_o,
  output logic [NB*CNT_W-1:0] wr_hit_cnt_o,
  output logic [NB*CNT_W-1:0] wr_miss_cnt_o,
  output logic [NB*CNT_W-1:0] act_miss_cnt_o,
  output logic [NB*CNT_W-1:0] unused_cnt_o
);
  localparam int unsigned IDX_W    = RANK_W + BG_W + BA_W;
  localparam int unsigned PER_RANK = NUM_BG * BANKS_PER_BG;

  logic [IDX_W-1:0]    addr_idx;
  logic [NB*CNT_W-1:0] cnt_bus [EV_N];

  assign addr_idx = {rank_i, bg_i, ba_i};

  for (genvar b = 0; b < NB; b++) begin : g_bank
    logic [EV_N-1:0] ev;

    dram_bank_tracker #(.ROW_W(ROW_W)) u_trk (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .valid_i    (cmd_valid_i),
      .cmd_i      (cmd_i),
      .sel_i      (addr_idx == IDX_W'(b)),
      .rank_sel_i (rank_i == RANK_W'(b / PER_RANK)),
      .ap_i       (ap_i),
      .row_i      (row_i),
      .ev_o       (ev)
    );

    for (genvar e = 0; e < EV_N; e++) begin : g_ev
      dram_sat_counter #(.W(CNT_W)) u_cnt (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .clr_i  (clr_i),
        .inc_i  (ev[e]),
        .q_o    (cnt_bus[e][b*CNT_W +: CNT_W])
      );
    end
  end

  assign rd_hit_cnt_o   = cnt_bus[EV_RD_HIT];
  assign rd_miss_cnt_o  = cnt_bus[EV_RD_MISS];
  assign wr_hit_cnt_o   = cnt_bus[EV_WR_HIT];
  assign wr_miss_cnt_o  = cnt_bus[EV_WR_MISS];
  assign act_miss_cnt_o = cnt_bus[EV_ACT_MISS];
  assign unused_cnt_o   = cnt_bus[EV_UNUSED];
endmodule

// File: rtl/dram_page_monitor_chk.sv
module dram_page_monitor_chk #(
  parameter int unsigned NB    = 32,
  parameter int unsigned CNT_W = 32
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                clr_i,
  input logic                cmd_valid_i,
  input logic [NB*CNT_W-1:0] rd_hit_cnt_o,
  input logic [NB*CNT_W-1:0] rd_miss_cnt_o,
  input logic [NB*CNT_W-1:0] wr_hit_cnt_o,
  input logic [NB*CNT_W-1:0] wr_miss_cnt_o,
  input logic [NB*CNT_W-1:0] act_miss_cnt_o,
  input logic [NB*CNT_W-1:0] unused_cnt_o
);
  localparam int unsigned TOT = 6 * NB;

  logic [TOT*CNT_W-1:0] all_c;
  assign all_c = {rd_hit_cnt_o, rd_miss_cnt_o, wr_hit_cnt_o,
                  wr_miss_cnt_o, act_miss_cnt_o, unused_cnt_o};

  // R1
  always @(negedge clk_i) begin
    if (!rst_ni) begin
      reset_zero_chk: assert (all_c == '0);
    end
  end

  for (genvar s = 0; s < TOT; s++) begin : g_s
    // R8
    no_decrease_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !clr_i |=> all_c[s*CNT_W +: CNT_W] >= $past(all_c[s*CNT_W +: CNT_W]));
    // R2
    single_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !clr_i |=> (all_c[s*CNT_W +: CNT_W] == $past(all_c[s*CNT_W +: CNT_W])) ||
                 (all_c[s*CNT_W +: CNT_W] == $past(all_c[s*CNT_W +: CNT_W]) + 1'b1));
    // R10
    idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!clr_i && !cmd_valid_i) |=> $stable(all_c[s*CNT_W +: CNT_W]));
    // R9
    clear_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      clr_i |=> all_c[s*CNT_W +: CNT_W] == '0);
  end
endmodule

bind dram_page_monitor dram_page_monitor_chk #(.NB(NB), .CNT_W(CNT_W)) u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .clr_i          (clr_i),
  .cmd_valid_i    (cmd_valid_i),
  .rd_hit_cnt_o   (rd_hit_cnt_o),
  .rd_miss_cnt_o  (rd_miss_cnt_o),
  .wr_hit_cnt_o   (wr_hit_cnt_o),
  .wr_miss_cnt_o  (wr_miss_cnt_o),
  .act_miss_cnt_o (act_miss_cnt_o),
  .unused_cnt_o   (unused_cnt_o)
);

// File: tb/dram_page_monitor_tb.sv
`timescale 1ns/1ps
module dram_page_monitor_tb;
  localparam int CW  = 4;
  localparam int NB  = 32;
  localparam int RW  = 17;
  localparam int MAXC = (1 << CW) - 1;

  logic clk = 1'b0;
  logic rst_ni, clr_i, cmd_valid_i, ap_i;
  logic [2:0] cmd_i;
  logic [0:0] rank_i;
  logic [1:0] bg_i, ba_i;
  logic [RW-1:0] row_i;
  logic [NB*CW-1:0] c_rh, c_rm, c_wh, c_wm, c_am, c_un;

  int checks = 0, errors = 0;
  int e_cnt [6][NB];
  bit m_open [NB];
  bit m_acc  [NB];
  logic [RW-1:0] m_row [NB];

  always #10 clk = ~clk;

  dram_page_monitor #(.CNT_W(CW)) u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .clr_i(clr_i), .cmd_valid_i(cmd_valid_i),
    .cmd_i(cmd_i), .ap_i(ap_i), .rank_i(rank_i), .bg_i(bg_i), .ba_i(ba_i),
    .row_i(row_i), .rd_hit_cnt_o(c_rh), .rd_miss_cnt_o(c_rm),
    .wr_hit_cnt_o(c_wh), .wr_miss_cnt_o(c_wm), .act_miss_cnt_o(c_am),
    .unused_cnt_o(c_un)
  );

  function automatic int get_cnt(int e, int i);
    case (e)
      0: return int'(c_rh[i*CW +: CW]);
      1: return int'(c_rm[i*CW +: CW]);
      2: return int'(c_wh[i*CW +: CW]);
      3: return int'(c_wm[i*CW +: CW]);
      4: return int'(c_am[i*CW +: CW]);
      default: return int'(c_un[i*CW +: CW]);
    endcase
  endfunction

  function automatic void bump(int e, int i);
    if (e_cnt[e][i] < MAXC) e_cnt[e][i]++;
  endfunction

  function automatic void close_bank(int i);
    if (m_open[i]) begin
      if (!m_acc[i]) bump(5, i);
      m_open[i] = 0;
      m_acc[i]  = 0;
    end
  endfunction

  // expected behaviour from R2..R10, index per R11
  function automatic void model(bit v, int c, int r, int g, int b,
                                logic [RW-1:0] row, bit ap, bit clr);
    int i;
    bit hit;
    i = (r * 4 + g) * 4 + b;
    if (v) begin
      case (c)
        1: begin
          if (m_open[i]) bump(4, i);
          m_open[i] = 1; m_acc[i] = 0; m_row[i] = row;
        end
        2, 3: begin
          hit = m_open[i] && (m_row[i] == row);
          if (hit) begin bump(c == 2 ? 0 : 2, i); m_acc[i] = 1; end
          else bump(c == 2 ? 1 : 3, i);
          if (ap) close_bank(i);
        end
        4: close_bank(i);
        5: for (int k = r * 16; k < r * 16 + 16; k++) close_bank(k);
        default: ;
      endcase
    end
    if (clr) for (int e = 0; e < 6; e++) for (int k = 0; k < NB; k++) e_cnt[e][k] = 0;
  endfunction

  task automatic check_all(string req);
    for (int e = 0; e < 6; e++) begin
      int bad;
      bad = -1;
      for (int k = 0; k < NB; k++)
        if (bad < 0 && get_cnt(e, k) != e_cnt[e][k]) bad = k;
      checks++;
      if (bad >= 0) begin
        errors++;
        $display("FAIL %s counter %0d bank %0d actual %0d expected %0d",
                 req, e, bad, get_cnt(e, bad), e_cnt[e][bad]);
      end
    end
  endtask

  task automatic issue(input int c, input int r, input int g, input int b,
                       input int row, input bit ap = 0, input bit v = 1,
                       input bit clr = 0);
    cmd_valid_i = v; cmd_i = 3'(c); rank_i = 1'(r); bg_i = 2'(g); ba_i = 2'(b);
    row_i = RW'(row); ap_i = ap; clr_i = clr;
    model(v, c, r, g, b, RW'(row), ap, clr);
    @(negedge clk);
    cmd_valid_i = 0; ap_i = 0; clr_i = 0; cmd_i = 3'd0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_ni = 0; clr_i = 0; cmd_valid_i = 0; cmd_i = 0; ap_i = 0;
    rank_i = 0; bg_i = 0; ba_i = 0; row_i = 0;
    for (int e = 0; e < 6; e++) for (int k = 0; k < NB; k++) e_cnt[e][k] = 0;
    for (int k = 0; k < NB; k++) begin m_open[k] = 0; m_acc[k] = 0; m_row[k] = 0; end
    repeat (3) @(negedge clk);
    check_all("R1");
    rst_ni = 1;
    @(negedge clk);
    check_all("R1");

    // R1 / R3: every bank closed after reset
    for (int k = 0; k < NB; k++) issue(2, k / 16, (k / 4) % 4, k % 4, 0);
    check_all("R1");
    for (int k = 0; k < NB; k++) issue(3, k / 16, (k / 4) % 4, k % 4, 0);
    check_all("R3");

    // R2 R3 R5 R11: full sweep of per-bank transitions
    for (int k = 0; k < NB; k++) begin
      int r, g, b;
      r = k / 16; g = (k / 4) % 4; b = k % 4;
      issue(1, r, g, b, 100 + k);       check_all("R11");
      issue(2, r, g, b, 100 + k);       check_all("R2");
      issue(3, r, g, b, 100 + k);       check_all("R2");
      issue(2, r, g, b, 101 + k);       check_all("R3");
      issue(4, r, g, b, 0);             check_all("R5");
      issue(1, r, g, b, 7);
      issue(3, r, g, b, 8);             check_all("R3");
      issue(4, r, g, b, 0);             check_all("R5");
      issue(4, r, g, b, 0);             check_all("R5");
    end

    // R4: activate over an open row
    issue(1, 1, 2, 3, 40);
    issue(1, 1, 2, 3, 41);              check_all("R4");
    issue(3, 1, 2, 3, 41);              check_all("R4");
    issue(2, 1, 2, 3, 40);              check_all("R4");
    issue(4, 1, 2, 3, 0);               check_all("R4");

    // R6: precharge-all only touches its rank
    issue(1, 0, 0, 0, 1); issue(1, 0, 1, 2, 2); issue(1, 0, 3, 3, 3);
    issue(2, 0, 1, 2, 2);
    issue(1, 1, 0, 0, 4); issue(1, 1, 3, 1, 5);
    issue(5, 0, 3, 1, 0);               check_all("R6");
    issue(2, 1, 0, 0, 4);               check_all("R6");
    issue(2, 0, 0, 0, 1);               check_all("R6");
    issue(5, 1, 0, 0, 0);               check_all("R6");

    // R7: auto-precharge after classification
    issue(1, 0, 2, 1, 9);
    issue(2, 0, 2, 1, 9, 1);            check_all("R7");
    issue(2, 0, 2, 1, 9);               check_all("R7");
    issue(1, 0, 2, 1, 9);
    issue(3, 0, 2, 1, 10, 1);           check_all("R7");
    issue(3, 0, 2, 1, 9);               check_all("R7");
    issue(3, 0, 2, 1, 9, 1);            check_all("R7");

    // R10: invalid cycles and reserved codes
    issue(1, 1, 1, 1, 33);
    issue(2, 1, 1, 1, 33, 0, 0);        check_all("R10");
    issue(4, 1, 1, 1, 0, 0, 0);         check_all("R10");
    issue(6, 1, 1, 1, 0);               check_all("R10");
    issue(7, 1, 1, 1, 0);               check_all("R10");
    issue(0, 1, 1, 1, 0);               check_all("R10");
    issue(2, 1, 1, 1, 33);              check_all("R10");

    // R8: saturation
    for (int n = 0; n < 20; n++) issue(2, 1, 1, 1, 33);
    check_all("R8");
    issue(1, 1, 1, 1, 34);
    for (int n = 0; n < 20; n++) issue(1, 1, 1, 1, 34);
    check_all("R8");

    // R9: clear wins, state still updates
    issue(3, 1, 1, 1, 34, 0, 1, 1);     check_all("R9");
    issue(4, 1, 1, 1, 0);               check_all("R9");
    issue(1, 0, 0, 3, 12, 0, 1, 1);     check_all("R9");
    issue(2, 0, 0, 3, 12);              check_all("R9");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule